// File: doc/BRIEF.md
# Dual-Compare 8-Bit Timer

This block is an 8-bit up-counter with two compare registers, a small register file on a simple single-cycle CPU bus, three sticky status flags and one timer output pin. The count clock is picked by a 3-bit field. It can be stopped, it can take one of four prescaler tick inputs, or it can take edges of an external clock. A 2-bit field sets how the counter clears: never, on compare A, on compare B, or on a rising edge of an external reset input. Clearing on a compare gives a programmable period. The second compare then places an edge inside that period, so the output pin can produce a PWM waveform or a square wave.

Software programs the control word and the output actions, then loads the compare constants. The counter runs without further CPU work. Compare matches and counter wrap are recorded in flags. A flag can be cleared only by reading it as 1 and then writing 0 to it, so an event that arrives between the read and the write is not lost without notice. A standby input returns the counter and the compare registers to their reset values.

Top module: `cmp_timer8`

## Requirements
- R1: After reset the block holds these values: counter 0x00, both compare registers 0xFF, control 0x00, status 0x00, `tmr_out` 0. A cycle with `standby` high returns the counter to 0x00 and both compare registers to 0xFF, and leaves the control register unchanged.
- R2: Clock select field ctrl[2:0]. Value 0 stops the counter. Values 1 to 4 advance the counter by one on each cycle in which `tick_in[value-1]` is high. Ticks on the other taps have no effect.
- R3: Clock select values 5, 6 and 7 count rising edges, falling edges or both edges of `ext_clk`, one increment per detected edge.
- R4: An increment from 0xFF to 0x00 sets the overflow flag, which is status bit 5.
- R5: Clear select ctrl[4:3]. With value 1 the counter clears on the clock edge that follows a compare-A match, and with value 2 on the edge that follows a compare-B match. The clear takes priority over an increment, so with a constant tick and compare value C the counter runs through C+1 states.
- R6: With clear select 3, a rising edge of `ext_rst` clears the counter on the next edge. With clear select 0, `ext_rst` has no effect.
- R7: While the counter equals compare A, status bit 6 is set. While the counter equals compare B, status bit 7 is set.
- R8: In a cycle that writes a compare register, the match for that register is suppressed. It neither clears the counter nor sets its flag.
- R9: On the first cycle of a match, the output pin takes an action. Compare A uses osel[1:0] (status bits 1:0) and compare B uses osel[3:2]. The codes are 0 keep, 1 drive 0, 2 drive 1, 3 toggle. A match that continues does not repeat the action.
- R10: When A and B matches begin in the same cycle and B's action is not keep, B's action decides the output.
- R11: A flag clears only when status is written with 0 in its bit after a status read that returned it as 1. Writing 1, or writing 0 without such a read, leaves the flag set.
- R12: A CPU write to the counter takes priority over both clear and increment in the same cycle.
- R13: Register map: address 0 is control {3'b0, clear select, clock select}; address 1 is status {CMFB, CMFA, OVF, 1'b0, osel[3:0]}; address 2 is the counter; address 3 is compare A; address 4 is compare B. Addresses 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Returns counter and compare registers to reset values |
| tick_in | input | 4 | Prescaler tick taps, one cycle wide |
| ext_clk | input | 1 | External count clock, sampled |
| ext_rst | input | 1 | External counter clear, rising edge |
| bus_cs | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| tmr_out | output | 1 | Timer output pin |

## Verification
A wrong count-enable or clear decision appears on the counter within one cycle. A sweep of compare values therefore shows it as a wrong count modulo the period after a fixed number of ticks. A lost or extra output event changes `tmr_out` one edge after the match begins, and it stays wrong until a later event. A bad flag arm state is visible right away on the status read that follows a write of 0 or 1. Write suppression of a compare shows up as a counter that clears one cycle too early.

// File: rtl/cmp_timer8_pkg.sv
package cmp_timer8_pkg;

    localparam int CNT_W    = 8;
    localparam int NUM_TAPS = 4;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 8;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CNT  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_CMPA = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_CMPB = 3'd4;

    localparam logic [2:0] CKS_STOP     = 3'd0;
    localparam logic [2:0] CKS_EXT_RISE = 3'd5;
    localparam logic [2:0] CKS_EXT_FALL = 3'd6;
    localparam logic [2:0] CKS_EXT_BOTH = 3'd7;

    typedef enum logic [1:0] {
        CLR_NONE = 2'd0,
        CLR_CMPA = 2'd1,
        CLR_CMPB = 2'd2,
        CLR_EXT  = 2'd3
    } clr_sel_e;

    typedef enum logic [1:0] {
        ACT_KEEP   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } out_act_e;

    typedef struct packed {
        clr_sel_e   clr;
        logic [2:0] cks;
    } ctrl_t;

    typedef struct packed {
        out_act_e b;
        out_act_e a;
    } osel_t;

    typedef struct packed {
        logic cmfb;
        logic cmfa;
        logic ovf;
    } flags_t;

    function automatic logic apply_act(input out_act_e act, input logic cur);
        case (act)
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            ACT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/ct8_clk_sel.sv
module ct8_clk_sel
    import cmp_timer8_pkg::*;
#(
    parameter int TAPS = NUM_TAPS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      cks,
    input  logic [TAPS-1:0] tick_in,
    input  logic            ext_clk,
    output logic            cnt_en
);

    logic ext_q;
    logic ext_rise, ext_fall;

    always_ff @(posedge clk) begin
        if (rst) ext_q <= 1'b0;
        else     ext_q <= ext_clk;
    end

    assign ext_rise = ext_clk & ~ext_q;
    assign ext_fall = ~ext_clk & ext_q;

    always_comb begin
        cnt_en = 1'b0;
        case (cks)
            CKS_STOP:     cnt_en = 1'b0;
            CKS_EXT_RISE: cnt_en = ext_rise;
            CKS_EXT_FALL: cnt_en = ext_fall;
            CKS_EXT_BOTH: cnt_en = ext_rise | ext_fall;
            default: begin
                for (int i = 0; i < TAPS; i++) begin
                    if (cks == 3'(i + 1)) cnt_en = tick_in[i];
                end
            end
        endcase
    end

    // R3: in both-edge mode any change of the sampled input is one count
    p_both_edges_r3: assert property (@(posedge clk) disable iff (rst)
        (cks == CKS_EXT_BOTH && ext_clk != ext_q) |-> cnt_en);

    // R2: a stopped clock never enables the counter
    p_stop_r2: assert property (@(posedge clk) disable iff (rst)
        (cks == CKS_STOP) |-> !cnt_en);

endmodule

// File: rtl/ct8_counter.sv
module ct8_counter
    import cmp_timer8_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         standby,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         inc_en,
    input  logic         clr_en,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || standby)  cnt_q <= '0;
        else if (wr_en)      cnt_q <= wr_data;
        else if (clr_en)     cnt_q <= '0;
        else if (inc_en)     cnt_q <= cnt_q + 1'b1;
    end

    assign cnt  = cnt_q;
    assign wrap = inc_en && !clr_en && !wr_en && !standby && (cnt_q == CNT_MAX);

    // R12: CPU write wins over clear and increment
    p_cpu_wins_r12: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !standby) |=> cnt_q == $past(wr_data));

    // R5: a granted clear empties the counter
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !wr_en && !standby) |=> cnt_q == '0);

    // R2: one enable, one step
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (inc_en && !clr_en && !wr_en && !standby) |=> cnt_q == $past(cnt_q) + 1'b1);

    // R1: standby returns the counter to zero
    p_standby_r1: assert property (@(posedge clk) disable iff (rst)
        standby |=> cnt_q == '0);

endmodule

// File: rtl/ct8_cmp_out.sv
module ct8_cmp_out
    import cmp_timer8_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    input  logic         wr_a,
    input  logic         wr_b,
    input  osel_t        osel,
    output logic         match_a,
    output logic         match_b,
    output logic         tmr_out
);

    logic ma_q, mb_q, out_q;
    logic ev_a, ev_b;
    logic out_after_a, out_next;

    assign match_a = (cnt == cmp_a) && !wr_a;
    assign match_b = (cnt == cmp_b) && !wr_b;
    assign ev_a    = match_a && !ma_q;
    assign ev_b    = match_b && !mb_q;

    always_comb begin
        out_after_a = ev_a ? apply_act(osel.a, out_q) : out_q;
        out_next    = ev_b ? apply_act(osel.b, out_after_a) : out_after_a;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ma_q  <= 1'b0;
            mb_q  <= 1'b0;
            out_q <= 1'b0;
        end else begin
            ma_q  <= match_a;
            mb_q  <= match_b;
            out_q <= out_next;
        end
    end

    assign tmr_out = out_q;

    // R9: no match onset, no output change
    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!ev_a && !ev_b) |=> $stable(out_q));

    // R10: B onset driving high wins over any A action
    p_b_high_r10: assert property (@(posedge clk) disable iff (rst)
        (ev_b && osel.b == ACT_HIGH) |=> out_q);

    // R10: B onset driving low wins over any A action
    p_b_low_r10: assert property (@(posedge clk) disable iff (rst)
        (ev_b && osel.b == ACT_LOW) |=> !out_q);

    // R9: a lasting match does not retrigger
    p_once_r9: assert property (@(posedge clk) disable iff (rst)
        (ma_q && mb_q && match_a && match_b) |=> $stable(out_q));

endmodule

// File: rtl/ct8_flags.sv
module ct8_flags
    import cmp_timer8_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  flags_t set_i,
    input  logic   rd_i,
    input  logic   wr_i,
    input  flags_t wdata_i,
    output flags_t flags_o
);

    localparam int NF = $bits(flags_t);

    logic [NF-1:0] f_q, arm_q, f_next, arm_next, set_v, wd_v;

    assign set_v = set_i;
    assign wd_v  = wdata_i;

    always_comb begin
        f_next   = (f_q & ~({NF{wr_i}} & arm_q & ~wd_v)) | set_v;
        arm_next = arm_q;
        if (wr_i)      arm_next = '0;
        else if (rd_i) arm_next = arm_q | f_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q   <= '0;
            arm_q <= '0;
        end else begin
            f_q   <= f_next;
            arm_q <= arm_next;
        end
    end

    assign flags_o = f_q;

    // R7 R4: an event always leaves its flag set
    p_set_r7: assert property (@(posedge clk) disable iff (rst)
        (|set_v) |=> ((f_q & $past(set_v)) == $past(set_v)));

    // R11: unarmed flags survive any status write
    p_keep_r11: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> ((f_q & $past(f_q & ~arm_q)) == $past(f_q & ~arm_q)));

    // R11: a flag never arms unless it was set
    p_arm_r11: assert property (@(posedge clk) disable iff (rst)
        ((arm_q & ~f_q) == '0));

endmodule

// File: rtl/cmp_timer8.sv
module cmp_timer8
    import cmp_timer8_pkg::*;
#(
    parameter int W    = CNT_W,
    parameter int TAPS = NUM_TAPS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              standby,
    input  logic [TAPS-1:0]   tick_in,
    input  logic              ext_clk,
    input  logic              ext_rst,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              tmr_out
);

    localparam int NF = $bits(flags_t);
    localparam int NC = $bits(ctrl_t);
    localparam int NO = $bits(osel_t);

    ctrl_t        ctrl_q;
    osel_t        osel_q;
    logic [W-1:0] cmp_a_q, cmp_b_q;
    logic         xrst_q, xrst_rise;

    logic wr_ctrl, wr_stat, rd_stat, wr_cnt, wr_a, wr_b;
    logic cnt_en, clr_en, wrap, match_a, match_b;
    logic [W-1:0] cnt;
    flags_t flags, flag_set, flag_wd;

    // bus decode
    always_comb begin
        wr_ctrl = bus_cs && bus_we  && (bus_addr == ADR_CTRL);
        wr_stat = bus_cs && bus_we  && (bus_addr == ADR_STAT);
        rd_stat = bus_cs && !bus_we && (bus_addr == ADR_STAT);
        wr_cnt  = bus_cs && bus_we  && (bus_addr == ADR_CNT);
        wr_a    = bus_cs && bus_we  && (bus_addr == ADR_CMPA);
        wr_b    = bus_cs && bus_we  && (bus_addr == ADR_CMPB);
    end

    // configuration and compare registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            osel_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[NC-1:0]);
            if (wr_stat) osel_q <= osel_t'(bus_wdata[NO-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || standby) begin
            cmp_a_q <= '1;
            cmp_b_q <= '1;
        end else begin
            if (wr_a) cmp_a_q <= bus_wdata;
            if (wr_b) cmp_b_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) xrst_q <= 1'b0;
        else     xrst_q <= ext_rst;
    end
    assign xrst_rise = ext_rst && !xrst_q;

    always_comb begin
        case (ctrl_q.clr)
            CLR_CMPA: clr_en = match_a;
            CLR_CMPB: clr_en = match_b;
            CLR_EXT:  clr_en = xrst_rise;
            default:  clr_en = 1'b0;
        endcase
    end

    ct8_clk_sel #(.TAPS(TAPS)) u_clk_sel (
        .clk     (clk),
        .rst     (rst),
        .cks     (ctrl_q.cks),
        .tick_in (tick_in),
        .ext_clk (ext_clk),
        .cnt_en  (cnt_en)
    );

    ct8_counter #(.W(W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .standby (standby),
        .wr_en   (wr_cnt),
        .wr_data (bus_wdata),
        .inc_en  (cnt_en),
        .clr_en  (clr_en),
        .cnt     (cnt),
        .wrap    (wrap)
    );

    ct8_cmp_out #(.W(W)) u_cmp_out (
        .clk     (clk),
        .rst     (rst),
        .cnt     (cnt),
        .cmp_a   (cmp_a_q),
        .cmp_b   (cmp_b_q),
        .wr_a    (wr_a),
        .wr_b    (wr_b),
        .osel    (osel_q),
        .match_a (match_a),
        .match_b (match_b),
        .tmr_out (tmr_out)
    );

    always_comb begin
        flag_set.cmfb = match_b;
        flag_set.cmfa = match_a;
        flag_set.ovf  = wrap;
        flag_wd       = flags_t'(bus_wdata[W-1 -: NF]);
    end

    ct8_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (flag_set),
        .rd_i    (rd_stat),
        .wr_i    (wr_stat),
        .wdata_i (flag_wd),
        .flags_o (flags)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_cs && !bus_we) begin
            case (bus_addr)
                ADR_CTRL: bus_rdata = W'(ctrl_q);
                ADR_STAT: bus_rdata = {flags, {(W-NF-NO){1'b0}}, osel_q};
                ADR_CNT:  bus_rdata = cnt;
                ADR_CMPA: bus_rdata = cmp_a_q;
                ADR_CMPB: bus_rdata = cmp_b_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R6: external clear edge empties the counter when selected
    p_ext_clr_r6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.clr == CLR_EXT && xrst_rise && !wr_cnt && !standby) |=> cnt == '0);

    // R8: a compare register under write never clears the counter
    p_suppress_r8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.clr == CLR_CMPA && wr_a && !cnt_en && !wr_cnt && !standby) |=> $stable(cnt));

    // R1: standby restores the compare constants
    p_standby_r1: assert property (@(posedge clk) disable iff (rst)
        standby |=> (cmp_a_q == '1 && cmp_b_q == '1));

endmodule

// File: tb/test_cmp_timer8.sv
module test_cmp_timer8;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       standby = 1'b0;
    logic [3:0] tick_in = '0;
    logic       ext_clk = 1'b0;
    logic       ext_rst = 1'b0;
    logic       bus_cs = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tmr_out;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] v;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cmp_timer8 i_cmp_timer8 (
        .clk       (clk),
        .rst       (rst),
        .standby   (standby),
        .tick_in   (tick_in),
        .ext_clk   (ext_clk),
        .ext_rst   (ext_rst),
        .bus_cs    (bus_cs),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tmr_out   (tmr_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_cs = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_cs = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tick_pulse(input logic [3:0] m);
        tick_in = m;
        @(posedge clk); @(negedge clk);
        tick_in = '0;
    endtask

    task automatic ext_pulse();
        ext_clk = 1'b1; @(posedge clk); @(negedge clk);
        ext_clk = 1'b0; @(posedge clk); @(negedge clk);
    endtask

    task automatic clear_flags();
        logic [7:0] s;
        rd(3'd1, s);
        wr(3'd1, {3'b000, 1'b0, s[3:0]});
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd2, v); check("R1 cnt", v, 8'h00);
        rd(3'd3, v); check("R1 cmpA", v, 8'hFF);
        rd(3'd4, v); check("R1 cmpB", v, 8'hFF);
        rd(3'd0, v); check("R1 ctrl", v, 8'h00);
        rd(3'd1, v); check("R1 status", v, 8'h00);
        check("R1 tmr_out", {7'b0, tmr_out}, 8'h00);

        // R13 register map readback
        wr(3'd0, 8'h1D); rd(3'd0, v); check("R13 ctrl", v, 8'h1D);
        rd(3'd5, v); check("R13 unmapped", v, 8'h00);
        wr(3'd0, 8'h00);

        // R2 tap selection sweep
        for (int t = 0; t < 4; t++) begin
            wr(3'd2, 8'h00);
            wr(3'd0, 8'(t + 1));
            for (int j = 0; j < 4; j++) begin
                for (int k = 0; k < t + 2; k++) tick_pulse(4'(1 << j));
            end
            rd(3'd2, v); check("R2 tap count", v, 8'(t + 2));
        end
        wr(3'd0, 8'h00); wr(3'd2, 8'h00);
        for (int k = 0; k < 3; k++) tick_pulse(4'hF);
        rd(3'd2, v); check("R2 stopped", v, 8'h00);

        // R3 external clock modes
        for (int m = 5; m <= 7; m++) begin
            wr(3'd2, 8'h00);
            wr(3'd0, 8'(m));
            for (int k = 0; k < 5; k++) ext_pulse();
            rd(3'd2, v); check("R3 ext edges", v, (m == 7) ? 8'd10 : 8'd5);
        end
        wr(3'd0, 8'h00);

        // R4 overflow, R11 flag clearing
        clear_flags();
        wr(3'd2, 8'hFE); wr(3'd0, 8'h01);
        tick_pulse(4'h1); tick_pulse(4'h1);
        wr(3'd0, 8'h00);
        rd(3'd2, v); check("R4 wrapped cnt", v, 8'h00);
        wr(3'd1, 8'h00);
        rd(3'd1, v); check("R11 write0 unread keeps", v & 8'h20, 8'h20);
        wr(3'd1, 8'hE0);
        idle(1);
        rd(3'd1, v);
        wr(3'd1, 8'hE0);
        rd(3'd1, v); check("R11 write1 keeps", v & 8'h20, 8'h20);
        wr(3'd1, 8'h00);
        rd(3'd1, v); check("R11 read then write0 clears", v & 8'h20, 8'h00);

        // R7 compare flags
        wr(3'd4, 8'h33); wr(3'd2, 8'h33); idle(1);
        rd(3'd1, v); check("R7 CMFB", v & 8'hC0, 8'h80);
        wr(3'd3, 8'h44); wr(3'd2, 8'h44); idle(1);
        rd(3'd1, v); check("R7 CMFA", v & 8'h40, 8'h40);
        wr(3'd2, 8'h00); wr(3'd4, 8'hFF);

        // R5 clear on compare A, period sweep
        for (int a = 0; a < 12; a++) begin
            wr(3'd0, 8'h08); wr(3'd3, 8'(a)); wr(3'd2, 8'h00); wr(3'd0, 8'h09);
            tick_in = 4'h1;
            repeat (29) @(posedge clk);
            @(negedge clk); tick_in = '0;
            rd(3'd2, v); check("R5 clear on A", v, 8'(29 % (a + 1)));
        end
        // R5 clear on compare B
        for (int b = 3; b < 8; b++) begin
            wr(3'd0, 8'h10); wr(3'd3, 8'hFF); wr(3'd4, 8'(b)); wr(3'd2, 8'h00); wr(3'd0, 8'h11);
            tick_in = 4'h1;
            repeat (40) @(posedge clk);
            @(negedge clk); tick_in = '0;
            rd(3'd2, v); check("R5 clear on B", v, 8'(40 % (b + 1)));
        end
        wr(3'd0, 8'h00); wr(3'd4, 8'hFF);

        // R6 external reset
        wr(3'd0, 8'h18); wr(3'd2, 8'h77);
        ext_rst = 1'b1; idle(1); ext_rst = 1'b0;
        rd(3'd2, v); check("R6 ext clear", v, 8'h00);
        wr(3'd0, 8'h00); wr(3'd2, 8'h77);
        ext_rst = 1'b1; idle(1); ext_rst = 1'b0;
        rd(3'd2, v); check("R6 ext ignored", v, 8'h77);

        // R8 compare suppression during write
        wr(3'd3, 8'hFF); wr(3'd2, 8'h40); wr(3'd0, 8'h08);
        clear_flags();
        wr(3'd3, 8'h40);
        wr(3'd3, 8'h41);
        rd(3'd2, v); check("R8 no clear", v, 8'h40);
        rd(3'd1, v); check("R8 no flag", v & 8'h40, 8'h00);

        // R12 write priority
        wr(3'd3, 8'h10); tick_in = 4'h1; wr(3'd0, 8'h09);
        wr(3'd2, 8'h10); wr(3'd2, 8'h22);
        tick_in = '0;
        rd(3'd2, v); check("R12 write wins", v, 8'h22);

        // R9 output actions
        wr(3'd0, 8'h00); wr(3'd2, 8'h00);
        wr(3'd3, 8'h50); wr(3'd4, 8'h60);
        wr(3'd1, 8'h06);
        wr(3'd2, 8'h50); idle(1);
        check("R9 A drive1", {7'b0, tmr_out}, 8'h01);
        wr(3'd2, 8'h60); idle(1);
        check("R9 B drive0", {7'b0, tmr_out}, 8'h00);
        wr(3'd1, 8'h03);
        wr(3'd2, 8'h00); wr(3'd2, 8'h50); idle(1);
        check("R9 toggle up", {7'b0, tmr_out}, 8'h01);
        idle(2);
        check("R9 held match no retrigger", {7'b0, tmr_out}, 8'h01);
        wr(3'd2, 8'h00); wr(3'd2, 8'h50); idle(1);
        check("R9 toggle down", {7'b0, tmr_out}, 8'h00);
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h00); wr(3'd2, 8'h50); idle(1);
        check("R9 keep", {7'b0, tmr_out}, 8'h00);

        // R10 B priority
        wr(3'd2, 8'h00); wr(3'd4, 8'h50);
        wr(3'd1, 8'h09);
        wr(3'd2, 8'h50); idle(1);
        check("R10 B wins", {7'b0, tmr_out}, 8'h01);

        // R1 standby
        wr(3'd0, 8'h0B);
        standby = 1'b1; idle(1); standby = 1'b0;
        rd(3'd2, v); check("R1 standby cnt", v, 8'h00);
        rd(3'd3, v); check("R1 standby cmpA", v, 8'hFF);
        rd(3'd4, v); check("R1 standby cmpB", v, 8'hFF);
        rd(3'd0, v); check("R1 standby ctrl kept", v, 8'h0B);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule